// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two W-bit unsigned operands using one W-bit adder, reused over W clock cycles. A pulse on `start` while the block is idle captures both operands. The multiplicand is held in a fixed register. The multiplier is loaded into the low half of a 2W-bit shift chain whose upper half is an accumulator cleared to zero.

On each iteration the block tests the least significant bit of the low half. When that bit is 1, it adds the multiplicand into the accumulator. The adder's carry and the whole chain then shift right by one position in the same clock, so one multiplier bit is consumed per cycle.

After W iterations the full 2W-bit product sits in the chain, with the accumulator as the upper half. `done` pulses for one cycle at that point, and the product stays on the output until the next accepted start. Signed operands and early exit are not supported.

Top module: `seq_mul`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` seen while idle sets `busy` from the next cycle. `busy` then stays high for exactly W consecutive cycles.
- R3: `done` is high for exactly one cycle, and that cycle is the first one after `busy` falls. `done` is never high together with `busy`.
- R4: In the `done` cycle, `product` equals the unsigned product of the operands captured at the accepted start, using all 2W bits.
- R5: A `start` seen while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R6: While idle with `start` low, `product` keeps its value.
- R7: k cycles after an accepted start (0 ≤ k ≤ W), `product` equals (M × (Q mod 2^k)) shifted left by W−k, plus (Q shifted right by k). Here M is the multiplicand and Q is the multiplier. The high W bits form the accumulator and the low W bits hold the remaining multiplier bits.
- R8: Changes on `mcand` and `mplier` after the start cycle do not affect the result.
- R9: Boundary operands give correct products: a zero operand gives 0, a one operand gives the other operand, and all-ones times all-ones gives (2^W−1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new multiplication (taken only when idle) |
| mcand | input | W | Multiplicand operand |
| mplier | input | W | Multiplier operand |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2W | Accumulator (high half) concatenated with the shift register (low half) |

## Verification
`product` exposes the accumulator and shift register directly. A wrong add decision, a lost carry or a missed shift therefore appears on the port in the same cycle it occurs, because the partial product no longer matches R7 for that iteration count. An off-by-one in the iteration counter appears as a `busy` window of the wrong length and a misplaced `done`. It also leaves the product shifted by one position at the end.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  m_r, acc_r, q_r;
  logic [CW-1:0] cnt_r;
  logic          busy_r, done_r;
  logic [W:0]    sum;

  assign sum     = {1'b0, acc_r} + {1'b0, (q_r[0] ? m_r : '0)};
  assign busy    = busy_r;
  assign done    = done_r;
  assign product = {acc_r, q_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r    <= '0;
      acc_r  <= '0;
      q_r    <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else if (busy_r) begin
      acc_r  <= sum[W:1];
      q_r    <= {sum[0], q_r[W-1:1]};
      cnt_r  <= cnt_r - 1'b1;
      busy_r <= (cnt_r != '0);
      done_r <= (cnt_r == '0);
    end else begin
      done_r <= 1'b0;
      if (start) begin
        m_r    <= mcand;
        acc_r  <= '0;
        q_r    <= mplier;
        cnt_r  <= LAST;
        busy_r <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int RW = $clog2(W + 1) + 1;

  logic [RW-1:0]  run_len;
  logic [W-1:0]   cap_a, cap_b;
  logic [2*W-1:0] want;

  assign want = (2*W)'(cap_a) * (2*W)'(cap_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      cap_a   <= '0;
      cap_b   <= '0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (start && !busy) begin
        cap_a <= mcand;
        cap_b <= mplier;
      end
    end
  end

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RW'(W)));
  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R4
  product_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == want));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind seq_mul seq_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
  .busy(busy), .done(done), .product(product)
);

// File: tb/test_seq_mul.sv
module test_seq_mul;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0, mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_run = 0, n_fail = 0, cycles = 0;

  seq_mul #(.W(W)) i_seq_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [2*W-1:0] ma, mq;
  int             mk;
  logic           m_busy, m_done;

  function automatic logic [2*W-1:0] partial(logic [2*W-1:0] a, logic [2*W-1:0] b, int k);
    logic [2*W-1:0] low;
    low = b & ((2*W)'((1 << k) - 1));
    return ((a * low) << (W - k)) | (b >> k);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ma = '0; mq = '0; mk = W; m_busy = 1'b0; m_done = 1'b0;
    end else if (m_busy) begin
      mk++;
      m_done = (mk == W);
      m_busy = (mk != W);
    end else begin
      m_done = 1'b0;
      if (start) begin
        ma = (2*W)'(mcand); mq = (2*W)'(mplier); mk = 0; m_busy = 1'b1;
      end
    end
  end

  task automatic check(string tag, logic [2*W-1:0] got, logic [2*W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cycles > 1) begin
      check("R2 busy", (2*W)'(busy), (2*W)'(m_busy));
      check("R3 done", (2*W)'(done), (2*W)'(m_done));
      check("R7 partial product", product, partial(ma, mq, mk));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog got %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic mul(logic [W-1:0] a, logic [W-1:0] b, bit disturb, string tag);
    logic [2*W-1:0] held;
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      for (int i = 0; i < W - 2; i++) begin
        start = 1'b1; mcand = ~a; mplier = W'($urandom);
        @(negedge clk);
      end
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(tag, product, (2*W)'(a) * (2*W)'(b));
    held = product;
    for (int i = 0; i < 2; i++) begin
      mcand = W'($urandom); mplier = W'($urandom);
      @(negedge clk);
      check("R6 idle hold", product, held);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset busy", (2*W)'(busy), '0);
    check("R1 reset done", (2*W)'(done), '0);
    check("R1 reset product", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {product[2*W-1:2], busy, done}, '0);

    mul(8'd13, 8'd11, 1'b0, "R4 worked case");
    mul(8'd0, 8'd200, 1'b0, "R9 zero operand");
    mul(8'd1, 8'd173, 1'b0, "R9 unit operand");
    mul(8'hFF, 8'hFF, 1'b0, "R9 all ones");
    mul(8'd97, 8'd58, 1'b1, "R5 R8 start and operands ignored while busy");

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        mul(W'(a), W'(b), 1'b0, "R4 exhaustive 4-bit");

    for (int i = 0; i < 150; i++)
      mul(W'($urandom), W'($urandom), (i % 3) == 0, "R4 random");

    start = 1'b1; mcand = 8'd77; mplier = 8'd99;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-run", {product, 1'b0, busy, done}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mul(8'd200, 8'd3, 1'b0, "R4 after mid-run reset");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule